// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-driven SPI master for serial flash parts. Software reaches it over a 32-bit register port with five word registers: control at 0x00, command at 0x04, status at 0x08, transmit data at 0x0C and receive data at 0x10. It drives the serial clock, the output data line and one active-low select per bank, and it samples the input data line. The bus runs in SPI mode 3 only. The clock idles high, data is launched on the falling edge and sampled on the rising edge.

One write to the command register starts a transaction. There are three kinds. A software send moves up to four bytes out of the transmit register and then gathers up to four bytes into the receive register. A status read sends opcode 0x05 and keeps the one byte that comes back. A write-enable sends opcode 0x06 with no data phase. Every kind runs inside a single chip-select window on the bank that the command names. A sticky finished flag tells software that the transaction has ended.

The control register holds two mode bits for a memory-mapped access path. That path is built elsewhere, so this block only stores the bits.

Top module: `spi_flash_ctl`

## Requirements
- R1: After reset, every select line is high, the serial clock is high, and the control, status and receive registers read 0.
- R2: The control register keeps bit 28 (software mode) and bit 29 (burst mode) exactly as written. Every other bit of it reads 0.
- R3: Command bit 7 starts a software send. Bits [2:0] give the transmit byte count, and any value above 4 counts as 4. Transmit bytes go out lowest byte of register 0x0C first, each byte MSB first. The output line changes only while the clock is low, so it is stable at every rising edge.
- R4: Bits [6:4] give the receive byte count, with values above 4 counting as 4. The receive bytes follow the transmit bytes, sampled on rising edges and MSB first. The first received byte lands in bits [7:0] of register 0x10, the next in [15:8], and so on. A software send clears register 0x10 to 0 when it starts.
- R5: Command bits [13:12] pick bank n, and only select line n goes low. It stays low through the whole transaction and rises exactly one clock period after the last rising edge. A transaction with no bytes keeps the select low for one period.
- R6: Command bit 10 sends opcode 0x05 and reads one byte (16 clocks in all). That byte appears in status bits [7:0].
- R7: Command bit 11 sends opcode 0x06 alone, which is 8 clocks.
- R8: Status bit 8 sets when any transaction ends and stays set. Writing 0 to that bit of register 0x08 clears it. Writing 1 leaves it unchanged.
- R9: Status bit 9 reads 1 while a transaction runs. Command writes during that time are ignored, both the trigger and the stored fields. Outside a transaction, bits [13:12], [6:4] and [2:0] read back as written.
- R10: When several trigger bits are set in one write, bit 10 wins over bit 11, and bit 11 wins over bit 7.
- R11: The serial clock period is CLK_DIV system cycles, half high and half low. Between transactions the clock idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when 1, read when 0 |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 4 | Active-low select, one per bank |

## Verification
The software send is driven with random transmit and receive counts from 0 to 7, random banks, random transmit words and random slave response streams.
- Lengths above four tell clamping apart from wrap-around.
- Mixed lengths show whether receive sampling starts exactly after the transmit bits.
- Distinct byte values expose byte-order or bit-order swaps.

Directed cases cover the rest:
- a status read with a known slave byte;
- a write-enable;
- triple and double trigger writes, for priority;
- a zero-length send;
- a command written in the middle of a long transaction;
- writes of 1 and then 0 to the finished flag.

Clock spacing and select release are timed in system cycles on every transaction.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_CMD  = 5'h04;
  localparam logic [4:0] A_STAT = 5'h08;
  localparam logic [4:0] A_TXD  = 5'h0C;
  localparam logic [4:0] A_RXD  = 5'h10;

  localparam int MAX_BYTES = 4;
  localparam int FIN_BIT   = 8;
  localparam int BUSY_BIT  = 9;
  localparam int SW_BIT    = 28;
  localparam int WB_BIT    = 29;
  localparam int BANK_LSB  = 12;

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SHIFT, SQ_TAIL} seq_t;
  typedef enum logic [1:0] {K_NONE, K_RDSR, K_WREN, K_SEND} kind_t;

  // byte count field limited to MAX_BYTES
  function automatic logic [2:0] clamp_len(logic [2:0] f);
    return (f > 3'(MAX_BYTES)) ? 3'(MAX_BYTES) : f;
  endfunction

  // total clock count for a transmit/receive pair
  function automatic logic [6:0] bits_for(logic [2:0] t, logic [2:0] r);
    return {({1'b0, t} + {1'b0, r}), 3'b000};
  endfunction

  // lowest byte first on the wire: move it to the top of the shift word
  function automatic logic [31:0] byte_swap32(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // trigger priority: status read, then write enable, then software send
  function automatic kind_t pick_kind(logic rdsr, logic wren, logic send);
    if (rdsr)      return K_RDSR;
    else if (wren) return K_WREN;
    else if (send) return K_SEND;
    return K_NONE;
  endfunction

endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= RELOAD;
    else if (!run)        cnt <= RELOAD;
    else if (cnt == '0)   cnt <= RELOAD;
    else                  cnt <= cnt - 1'b1;
  end

  assign tick = run && (cnt == '0);

  // a tick never arrives in the first cycle of a run
  assert_tick_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!tick || HALF == 1));
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_word,
  input  logic        fall,
  input  logic        rise,
  input  logic        rx_phase,
  input  logic        miso,
  output logic        mosi,
  output logic        rx_done,
  output logic [7:0]  rx_byte
);
  logic [31:0] tx_sr;
  logic [2:0]  rx_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      mosi  <= 1'b1;
    end else if (load) begin
      tx_sr <= load_word;
    end else if (fall) begin
      mosi  <= tx_sr[31];
      tx_sr <= {tx_sr[30:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      rx_cnt  <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (load) begin
        rx_cnt <= '0;
      end else if (rise && rx_phase) begin
        rx_byte <= {rx_byte[6:0], miso};
        rx_cnt  <= rx_cnt + 1'b1;
        rx_done <= (rx_cnt == 3'd7);
      end
    end
  end

  // completed bytes are at least eight rising edges apart
  assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
endmodule

// File: rtl/spi_flash_ctl.sv
module spi_flash_ctl
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [4:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic [NUM_BANKS-1:0] cs_n
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  seq_t              state;
  kind_t             kind_q, kind_new;
  logic              ctl_sw, ctl_wb;
  logic [2:0]        cmd_txn, cmd_rxn;
  logic [BANK_W-1:0] cmd_bank, act_bank;
  logic [31:0]       txd_q, rxd_q;
  logic [7:0]        stat_byte;
  logic              fin;
  logic [6:0]        bit_idx, tot_bits, tx_bits;
  logic [1:0]        rx_idx;
  logic              tail_half;
  logic              sclk_q;

  // named internal events
  logic        wr_ev, wr_cmd, wr_stat, busy, cmd_take, start_ev;
  logic        tick, fall_ev, rise_ev, last_rise, release_ev, rx_phase;
  logic        rx_done;
  logic [7:0]  rx_byte;
  logic [2:0]  n_tx, n_rx;
  logic [31:0] n_word;
  logic [6:0]  n_tot;

  assign wr_ev    = reg_en && reg_we;
  assign wr_cmd   = wr_ev && (reg_addr == A_CMD);
  assign wr_stat  = wr_ev && (reg_addr == A_STAT);
  assign busy     = (state != SQ_IDLE);
  assign cmd_take = wr_cmd && !busy;
  assign kind_new = pick_kind(reg_wdata[10], reg_wdata[11], reg_wdata[7]);
  assign start_ev = cmd_take && (kind_new != K_NONE);

  assign fall_ev    = tick && (state == SQ_SHIFT) && sclk_q;
  assign rise_ev    = tick && (state == SQ_SHIFT) && !sclk_q;
  assign last_rise  = rise_ev && (bit_idx == tot_bits - 7'd1);
  assign release_ev = tick && (state == SQ_TAIL) && tail_half;
  assign rx_phase   = (bit_idx >= tx_bits);

  always_comb begin
    n_tx   = clamp_len(reg_wdata[2:0]);
    n_rx   = clamp_len(reg_wdata[6:4]);
    n_word = byte_swap32(txd_q);
    case (kind_new)
      K_RDSR: begin n_tx = 3'd1; n_rx = 3'd1; n_word = {OP_RDSR, 24'h0}; end
      K_WREN: begin n_tx = 3'd1; n_rx = 3'd0; n_word = {OP_WREN, 24'h0}; end
      default: ;
    endcase
    n_tot = bits_for(n_tx, n_rx);
  end

  spi_eng_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  spi_eng_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(start_ev), .load_word(n_word),
    .fall(fall_ev), .rise(rise_ev), .rx_phase(rx_phase), .miso(miso),
    .mosi(mosi), .rx_done(rx_done), .rx_byte(rx_byte)
  );

  // register bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_sw   <= 1'b0;
      ctl_wb   <= 1'b0;
      cmd_txn  <= '0;
      cmd_rxn  <= '0;
      cmd_bank <= '0;
      txd_q    <= '0;
    end else if (wr_ev) begin
      if (reg_addr == A_CTRL) begin
        ctl_sw <= reg_wdata[SW_BIT];
        ctl_wb <= reg_wdata[WB_BIT];
      end
      if (cmd_take) begin
        cmd_txn  <= reg_wdata[2:0];
        cmd_rxn  <= reg_wdata[6:4];
        cmd_bank <= reg_wdata[BANK_LSB +: BANK_W];
      end
      if (reg_addr == A_TXD) txd_q <= reg_wdata;
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      kind_q    <= K_NONE;
      act_bank  <= '0;
      bit_idx   <= '0;
      tot_bits  <= '0;
      tx_bits   <= '0;
      tail_half <= 1'b0;
      sclk_q    <= 1'b1;
    end else begin
      if (start_ev) begin
        kind_q    <= kind_new;
        act_bank  <= reg_wdata[BANK_LSB +: BANK_W];
        bit_idx   <= '0;
        tot_bits  <= n_tot;
        tx_bits   <= {1'b0, n_tx, 3'b000};
        tail_half <= 1'b0;
        sclk_q    <= 1'b1;
        state     <= (n_tot == '0) ? SQ_TAIL : SQ_SHIFT;
      end else begin
        if (fall_ev) sclk_q <= 1'b0;
        if (rise_ev) begin
          sclk_q  <= 1'b1;
          bit_idx <= bit_idx + 7'd1;
        end
        if (last_rise) begin
          state     <= SQ_TAIL;
          tail_half <= 1'b0;
        end
        if (tick && state == SQ_TAIL) begin
          if (tail_half) state <= SQ_IDLE;
          else           tail_half <= 1'b1;
        end
      end
    end
  end

  // receive capture, status byte and finished flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q     <= '0;
      rx_idx    <= '0;
      stat_byte <= '0;
      fin       <= 1'b0;
    end else begin
      if (start_ev) begin
        rx_idx <= '0;
        if (kind_new == K_SEND) rxd_q <= '0;
      end else if (rx_done) begin
        rx_idx <= rx_idx + 2'd1;
        if (kind_q == K_RDSR) stat_byte <= rx_byte;
        else                  rxd_q[8*rx_idx +: 8] <= rx_byte;
      end
      if (release_ev)                         fin <= 1'b1;
      else if (wr_stat && !reg_wdata[FIN_BIT]) fin <= 1'b0;
    end
  end

  assign sclk = sclk_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
    assign cs_n[g] = !(busy && (act_bank == BANK_W'(g)));
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[SW_BIT] = ctl_sw;
        reg_rdata[WB_BIT] = ctl_wb;
      end
      A_CMD: begin
        reg_rdata[2:0] = cmd_txn;
        reg_rdata[6:4] = cmd_rxn;
        reg_rdata[BANK_LSB +: BANK_W] = cmd_bank;
      end
      A_STAT: begin
        reg_rdata[7:0]      = stat_byte;
        reg_rdata[FIN_BIT]  = fin;
        reg_rdata[BUSY_BIT] = busy;
      end
      A_TXD:   reg_rdata = txd_q;
      A_RXD:   reg_rdata = rxd_q;
      default: reg_rdata = '0;
    endcase
  end

  // assertions
  assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_cs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !release_ev) |=> (busy && $stable(cs_n)));
  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && (&cs_n)));
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  assert_fin_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !(wr_stat && !reg_wdata[FIN_BIT])) |=> fin);
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cmd) |=> ($stable({cmd_txn, cmd_rxn, cmd_bank, act_bank}) && $stable(tot_bits)));
  assert_done_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> (fin && !busy));
endmodule

// File: tb/sim_spi_flash_ctl.sv
module sim_spi_flash_ctl;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, mosi;
  logic        miso = 1'b1;
  logic [3:0]  cs_n;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  spi_flash_ctl #(.CLK_DIV(DIV), .NUM_BANKS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #5 clk = ~clk;

  // bus monitor and slave model, all at the falling system edge
  int          cyc = 0;
  logic        sclk_p = 1'b1;
  logic        idle_p = 1'b1;
  logic [63:0] mo_bits;
  logic [63:0] pat = '0;
  int          rises, fidx, last_rise_t, rel_t, start_t, bad_period;
  logic [3:0]  cs_first;
  bit          cs_moved;

  always @(negedge clk) begin
    cyc++;
    if (idle_p && !(&cs_n)) begin
      rises = 0; fidx = 0; mo_bits = '0; bad_period = 0;
      cs_first = cs_n; cs_moved = 0; start_t = cyc;
    end
    if (!(&cs_n)) begin
      if (!sclk_p && sclk) begin
        mo_bits = {mo_bits[62:0], mosi};
        if (rises > 0 && (cyc - last_rise_t) != DIV) bad_period++;
        last_rise_t = cyc;
        rises++;
        if (cs_n !== cs_first) cs_moved = 1;
      end
      if (sclk_p && !sclk) begin
        if (fidx < 64) miso = pat[63 - fidx];
        fidx++;
      end
    end
    if (!idle_p && (&cs_n)) rel_t = cyc;
    sclk_p = sclk;
    idle_p = &cs_n;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(5'h08, s);
      if (!s[9]) break;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int clampb(int f);
    return (f > 4) ? 4 : f;
  endfunction

  function automatic logic [63:0] exp_tx(logic [31:0] tx, int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r = {r[55:0], tx[8*i +: 8]};
    return r;
  endfunction

  function automatic logic [31:0] exp_rx(logic [63:0] p, int ntx, int nrx);
    logic [31:0] r = '0;
    for (int j = 0; j < nrx; j++)
      for (int b = 0; b < 8; b++)
        r[8*j + 7 - b] = p[63 - 8*(ntx + j) - b];
    return r;
  endfunction

  // one software send, checked in full
  task automatic sw_send(input int txf, input int rxf, input int bank,
                         input logic [31:0] tx, input logic [63:0] p);
    logic [31:0] v;
    int nt, nr;
    nt = clampb(txf); nr = clampb(rxf);
    wr(5'h0C, tx);
    wr(5'h08, 32'h0);
    pat = p;
    wr(5'h04, (bank << 12) | (rxf << 4) | txf | 32'h80);
    wait_idle();
    chk("R3 clock count", 64'(rises), 64'(8*(nt+nr)));
    chk("R3 transmit bits", mo_bits >> (8*nr), exp_tx(tx, nt));
    rd(5'h10, v);
    chk("R4 receive word", 64'(v), 64'(exp_rx(p, nt, nr)));
    chk("R5 bank select", 64'(cs_first), 64'(~(4'b1 << bank) & 4'hF));
    chk("R5 select held", 64'(cs_moved), 64'(0));
    if (nt + nr > 0) begin
      chk("R11 clock period", 64'(bad_period), 64'(0));
      chk("R5 release delay", 64'(rel_t - last_rise_t), 64'(DIV));
    end else begin
      chk("R5 empty window", 64'(rel_t - start_t), 64'(DIV));
    end
    rd(5'h08, v);
    chk("R8 finished set", 64'(v[9:8]), 64'(2'b01));
    rd(5'h04, v);
    chk("R9 command readback", 64'(v), 64'((bank << 12) | (rxf << 4) | txf));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 select lines", 64'(cs_n), 64'hF);
    chk("R1 clock idle", 64'(sclk), 64'(1));
    rd(5'h00, v); chk("R1 control", 64'(v), 64'(0));
    rd(5'h08, v); chk("R1 status", 64'(v), 64'(0));
    rd(5'h10, v); chk("R1 receive", 64'(v), 64'(0));

    // R2 control bits
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); chk("R2 control mask", 64'(v), 64'h3000_0000);
    wr(5'h00, 32'h2000_0000);
    rd(5'h00, v); chk("R2 burst only", 64'(v), 64'h2000_0000);

    // R7 write enable on bank 2
    pat = '0;
    wr(5'h04, 32'h0000_2800);
    wait_idle();
    chk("R7 clock count", 64'(rises), 64'(8));
    chk("R7 opcode", mo_bits, 64'h06);
    chk("R5 bank 2", 64'(cs_first), 64'hB);
    chk("R5 release delay", 64'(rel_t - last_rise_t), 64'(DIV));

    // R8 finished flag
    rd(5'h08, v); chk("R8 set after write enable", 64'(v[8]), 64'(1));
    wr(5'h08, 32'h0000_0100);
    rd(5'h08, v); chk("R8 write one keeps", 64'(v[8]), 64'(1));
    wr(5'h08, 32'h0);
    rd(5'h08, v); chk("R8 write zero clears", 64'(v[8]), 64'(0));

    // R6 status read on bank 1
    pat = {8'h00, 8'hA5, 48'h0};
    wr(5'h04, 32'h0000_1400);
    wait_idle();
    chk("R6 clock count", 64'(rises), 64'(16));
    chk("R6 opcode", 64'(mo_bits[15:8]), 64'h05);
    rd(5'h08, v); chk("R6 status byte", 64'(v[8:0]), 64'h1A5);
    chk("R5 bank 1", 64'(cs_first), 64'hD);

    // R10 priority
    wr(5'h08, 32'h0);
    pat = {8'h00, 8'h3C, 48'h0};
    wr(5'h04, 32'h0000_0C83);
    wait_idle();
    chk("R10 status read wins", 64'(rises), 64'(16));
    chk("R10 opcode 05", 64'(mo_bits[15:8]), 64'h05);
    wr(5'h04, 32'h0000_0883);
    wait_idle();
    chk("R10 write enable over send", 64'(rises), 64'(8));
    chk("R10 opcode 06", mo_bits, 64'h06);

    // R3/R4 directed send: four out, three in
    sw_send(4, 3, 3, 32'h1234_5678, 64'h0000_0000_C2_20_15_00);
    // R4 receive cleared by a send with no receive bytes
    sw_send(1, 0, 0, 32'h0000_00E7, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5 zero-length send
    sw_send(0, 0, 2, 32'h0, 64'h0);

    // R9 writes during a long transaction
    wr(5'h0C, 32'hCAFE_F00D);
    pat = {$urandom, $urandom};
    wr(5'h04, 32'h0000_00C4 | 32'h0000_0040);
    repeat (20) @(negedge clk);
    rd(5'h08, v); chk("R9 busy flag", 64'(v[9]), 64'(1));
    wr(5'h04, 32'h0000_3C11);
    rd(5'h04, v); chk("R9 command ignored", 64'(v), 64'h44);
    wait_idle();
    chk("R9 transaction untouched", 64'(rises), 64'(64));
    chk("R9 bank untouched", 64'(cs_first), 64'hE);
    rd(5'h10, v); chk("R4 long receive", 64'(v), 64'(exp_rx(pat, 4, 4)));

    // random sends, counts above four included
    for (int k = 0; k < 24; k++) begin
      sw_send(int'($urandom % 8), int'($urandom % 8), int'($urandom % 4),
              $urandom, {$urandom, $urandom});
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule